// File: doc/BRIEF.md
# Pulse-Swallow Integer-N Feedback Divider

This block divides a fast input clock by an integer ratio N = 4·B + A. A prescaler that can divide by either 4 or 5 drives two counters. The main counter B sets the number of prescaler cycles in one output period. The swallow counter A sets how many of those prescaler cycles use the longer count of 5. In a frequency synthesizer it sits in the feedback path: one feedback pulse is sent to the phase comparator for every N oscillator cycles.

The programmed values `bVal` and `aVal` are checked against the range the counters can realize. An illegal pair raises `rangeErr` and is ignored. A legal pair is taken only when an output period ends, so a period that has already started always finishes with the ratio it began with. After reset the divider runs with B = 4 and A = 0 (N = 16) until the first period boundary.

Top module: `pswDivTop`

## Requirements
- R1: With a legal pair in effect, the rising samples of `fbPulse` are exactly 4·B + A input clock cycles apart.
- R2: `fbPulse` is high for exactly one clock cycle in each output period.
- R3: Every B from 4 to 63 together with every A from 0 to 3 is accepted. This range includes the smallest ratio, N = 16 (B=4, A=0), and the largest, N = 255 (B=63, A=3).
- R4: `rangeErr` is high in the same cycle that `bVal` is below 4, and low whenever `bVal` is 4 or more. All values of the 2-bit A are in range.
- R5: A pair flagged by `rangeErr` has no effect. The divider keeps the last legal ratio, and this can be seen in the spacing of the `fbPulse` samples.
- R6: A change to `bVal` or `aVal` is picked up only at the end of an output period. The period in progress completes with the old ratio.
- R7: Reset holds `fbPulse` low. The first pulse after reset is released comes 16 cycles later, because the default setting is B = 4, A = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock to be divided |
| rstN | input | 1 | Active-low synchronous reset |
| bVal | input | 6 | Main counter value B, legal from 4 to 63 |
| aVal | input | 2 | Swallow counter value A, 0 to 3 |
| fbPulse | output | 1 | Single-cycle pulse once per N input cycles |
| rangeErr | output | 1 | High while the presented pair cannot be realized |

## Verification
The divider is stepped through every legal (B, A) pair in ascending order. This shows that each swallow count adds exactly one cycle, and that each step of B adds four. Every new pair is presented just after a pulse. The first interval must therefore show the old ratio and the second interval the new one, which separates a correct boundary latch from one that reacts straight away. Random pairs then follow, drawn over the full 6-bit B range, so illegal values of B are mixed with legal ones. These separate a correctly held ratio from one that has been corrupted, and they check that the flag follows B in the same cycle.

// File: rtl/pswDivPkg.sv
package pswDivPkg;
  // Strobes sent from the counter control to the prescaler datapath
  typedef struct packed {
    logic useFive;    // prescaler runs its long (P+1) modulus this cycle group
    logic endPeriod;  // last input cycle of the output period
  } pdStrobe_t;
endpackage

// File: rtl/pswDivCtrl.sv
module pswDivCtrl
  import pswDivPkg::*;
#(
  parameter int BW    = 6,
  parameter int AW    = 2,
  parameter int BMIN  = 4,
  parameter int DEF_B = 4,
  parameter int DEF_A = 0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [BW-1:0] bVal,
  input  logic [AW-1:0] aVal,
  input  logic          presTick,
  output pdStrobe_t     strb,
  output logic          rangeErr
);
  localparam logic [BW-1:0] B_MIN  = BW'(BMIN);
  localparam logic [BW-1:0] B_DEF  = BW'(DEF_B);
  localparam logic [AW-1:0] A_DEF  = AW'(DEF_A);
  localparam logic [BW-1:0] B_LAST = BW'(1);

  logic [BW-1:0] activeB, bLeft;
  logic [AW-1:0] activeA, aLeft;
  logic          legal, endPeriod;

  // A pair is realizable when B reaches its floor and A never exceeds B
  assign legal     = (bVal >= B_MIN) && (int'(aVal) <= int'(bVal));
  assign rangeErr  = !legal;
  assign endPeriod = presTick && (bLeft == B_LAST);

  always_comb begin
    strb.useFive   = (aLeft != '0);
    strb.endPeriod = endPeriod;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeB <= B_DEF;
      activeA <= A_DEF;
      bLeft   <= B_DEF;
      aLeft   <= A_DEF;
    end else if (endPeriod) begin
      if (legal) begin
        activeB <= bVal;
        activeA <= aVal;
        bLeft   <= bVal;
        aLeft   <= aVal;
      end else begin
        bLeft   <= activeB;
        aLeft   <= activeA;
      end
    end else if (presTick) begin
      bLeft <= bLeft - 1'b1;
      if (aLeft != '0) aLeft <= aLeft - 1'b1;
    end
  end

  // R6
  setting_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !endPeriod |=> $stable(activeB) && $stable(activeA));

  // R5
  illegal_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endPeriod && rangeErr) |=> $stable(activeB) && $stable(activeA));

  // R1
  swallow_le_main_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(aLeft) <= int'(bLeft));

  // R3
  active_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeB >= B_MIN);
endmodule

// File: rtl/pswDivPath.sv
module pswDivPath
  import pswDivPkg::*;
#(
  parameter int PBASE = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  pdStrobe_t strb,
  output logic      presTick,
  output logic      fbPulse
);
  localparam int CW = $clog2(PBASE + 1);
  localparam logic [CW-1:0] LIM_SHORT = CW'(PBASE - 1);
  localparam logic [CW-1:0] LIM_LONG  = CW'(PBASE);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim      = strb.useFive ? LIM_LONG : LIM_SHORT;
  assign presTick = (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      fbPulse <= 1'b0;
    end else begin
      cnt     <= presTick ? '0 : cnt + 1'b1;
      fbPulse <= strb.endPeriod;
    end
  end

  // R1
  presc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LIM_LONG);

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |=> !fbPulse);
endmodule

// File: rtl/pswDivTop.sv
module pswDivTop
  import pswDivPkg::*;
#(
  parameter int BW    = 6,
  parameter int AW    = 2,
  parameter int PBASE = 4,
  parameter int BMIN  = 4,
  parameter int DEF_B = 4,
  parameter int DEF_A = 0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [BW-1:0] bVal,
  input  logic [AW-1:0] aVal,
  output logic          fbPulse,
  output logic          rangeErr
);
  pdStrobe_t strb;
  logic      presTick;

  pswDivCtrl #(.BW(BW), .AW(AW), .BMIN(BMIN), .DEF_B(DEF_B), .DEF_A(DEF_A)) uCtrl (
    .clk(clk), .rstN(rstN), .bVal(bVal), .aVal(aVal),
    .presTick(presTick), .strb(strb), .rangeErr(rangeErr)
  );

  pswDivPath #(.PBASE(PBASE)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .presTick(presTick), .fbPulse(fbPulse)
  );

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !fbPulse);
endmodule

// File: tb/sim_pswDivTop.sv
`timescale 1ns/1ps
module sim_pswDivTop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] bVal = 6'd4;
  logic [1:0] aVal = 2'd0;
  logic       fbPulse, rangeErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pswDivTop u0 (.clk(clk), .rstN(rstN), .bVal(bVal), .aVal(aVal),
                .fbPulse(fbPulse), .rangeErr(rangeErr));

  function automatic int expN(int b, int a);
    return 4 * b + a;
  endfunction

  function automatic bit isLegal(int b, int a);
    return (b >= 4) && (a <= b);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Count negedge samples up to and including the next high fbPulse
  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1 && fbPulse) check(0, "R2", 1, 0);
    end while (!fbPulse && n < 1000);
  endtask

  int curN = 16;

  task automatic applyPair(int b, int a, string tag);
    int n;
    bit ok;
    ok = isLegal(b, a);
    bVal = 6'(b);
    aVal = 2'(a);
    #1;
    check(rangeErr == !ok, "R4", int'(rangeErr), int'(!ok));
    measure(n);
    check(n == curN, "R6", n, curN);
    if (ok) curN = expN(b, a);
    measure(n);
    check(n == curN, ok ? tag : "R5", n, curN);
  endtask

  initial begin
    #(8 * 200000);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(fbPulse == 1'b0, "R7", int'(fbPulse), 0);
    check(rangeErr == 1'b0, "R7", int'(rangeErr), 0);
    rstN = 1'b1;
    measure(n);
    check(n == 16, "R7", n, 16);

    // R3 / R1: full legal sweep, covering N=16 and N=255
    for (int b = 4; b < 64; b++)
      for (int a = 0; a < 4; a++)
        applyPair(b, a, (b == 63 && a == 3) || (b == 4 && a == 0) ? "R3" : "R1");

    // R5 / R4: directed illegal values around the floor
    applyPair(3, 3, "R5");
    applyPair(0, 0, "R5");
    applyPair(4, 0, "R1");

    // Random pairs across the full 6-bit range
    for (int i = 0; i < 80; i++) begin
      int b, a;
      b = int'($urandom % 64);
      a = int'($urandom % 4);
      applyPair(b, a, "R1");
    end
    summary();
  end
endmodule